// File: doc/BRIEF.md
# Buffered-Duty PWM Timer Channel

This block is one channel of an 8-bit pulse-width timer. A free-running counter runs from 0 up to 249 and then returns to 0, so each output period lasts 250 counts. The counter moves only on a tick that a 3-bit clock select picks from eight prescaler tick inputs. A duty register sets how many counts of each period the output is high. Counts 1 through D are high and all other counts are low. Duty values of 250 and above give a constant high output.

Software writes the duty through one strobe and writes the enable, polarity and clock select through a second strobe. While the channel runs, a duty write goes into a buffer and becomes active only at the next period boundary, so a period never carries half of one duty and half of another. While the channel is stopped, the counter is held at 0, the pin is released, and a duty write takes effect at once.

The channel's control is a two-state machine. In `ST_IDLE` the counter is held and the pin is released. In `ST_RUN` the counter advances on the selected tick. The START transition goes from `ST_IDLE` to `ST_RUN` on a control write with enable set. The STOP transition goes from `ST_RUN` to `ST_IDLE` on a control write with enable clear. Any other control write keeps the current state.

Top module: `pwm_chan_top`

## Requirements
- R1: In `ST_RUN` the counter steps 0,1,…,249 on selected ticks and then returns to 0, so one period is 250 selected ticks long.
- R2: An active duty of 0 keeps the logical output at 0 for the whole period.
- R3: An active duty of 250 to 255 keeps the logical output at 1 for the whole period.
- R4: For an active duty D in 1..249, the logical output is 1 while the counter is in 1..D and 0 while the counter is 0 or greater than D. It rises on the step from 0 to 1 and falls once the counter passes D.
- R5: A duty write in `ST_RUN` is held in the buffer and becomes active on the cycle in which the counter wraps from 249 to 0. A write made on that same wrap cycle becomes active at that wrap.
- R6: In `ST_IDLE` the counter is 0, `pwm_oe` is 0 and `pwm_o` is 0. In this state the active duty follows the buffer, so a duty write takes effect at once.
- R7: `pwm_o` equals the logical output when polarity is 0 and its inverse when polarity is 1, whenever `pwm_oe` is 1.
- R8: Clock select value k (0..7) makes the counter advance only on cycles where `tick_in[k]` is 1.
- R9: START sets the counter to 0, ignores any tick in that cycle and runs with the duty that is active. The first counted period therefore begins at logical 0 unless the duty is 250 or more.
- R10: A synchronous active-low reset clears the counter, the buffered and active duty, the enable, the polarity and the clock select. This leaves the pin released and at 0.
- R11: A control write with enable set while already in `ST_RUN` keeps counting without a restart and applies the new polarity and clock select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| duty_we | input | 1 | Duty write strobe |
| duty_wdata | input | 8 | Duty write value |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_en | input | 1 | Enable value written with ctrl_we |
| ctrl_pol | input | 1 | Polarity value written with ctrl_we (1 = inverted) |
| ctrl_cks | input | 3 | Clock select value written with ctrl_we |
| tick_in | input | 8 | Prescaler tick inputs, one per clock select code |
| pwm_o | output | 1 | PWM pin level, 0 when released |
| pwm_oe | output | 1 | High while the channel drives the pin |

## Verification
The bench changes the duty in the middle of a period and checks that the waveform keeps the old width until the wrap. A design that applied writes at once would show a period with a mixed width. Duty values 0, 250 and 252 are tested against a limit of 249. A design that compared against 255 would pulse instead of holding a constant level, and one that mishandled 0 would emit a one-count spike. The bench also stops the channel with a write pending, restarts it, selects a slow tick, and re-enables the channel while it runs. An off-by-one wrap, a counter gated by the wrong tick, or a restart on re-enable would each shift every later edge and fail the cycle-by-cycle comparison.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } chan_state_t;
endpackage

// File: rtl/pwm_tick_sel.sv
module pwm_tick_sel #(
    parameter int N_TICK = 8,
    localparam int SEL_W = $clog2(N_TICK)
) (
    input  logic [N_TICK-1:0] tick_in,
    input  logic [SEL_W-1:0]  sel,
    output logic              tick_o
);
    logic [N_TICK-1:0] hit;

    // one-hot match per source, then OR-reduce
    for (genvar k = 0; k < N_TICK; k++) begin : g_src
        assign hit[k] = tick_in[k] && (sel == SEL_W'(k));
    end

    assign tick_o = |hit;
endmodule

// File: rtl/pwm_ctrl_fsm.sv
module pwm_ctrl_fsm
    import pwm_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int PERIOD_LEN = 250,
    parameter int SEL_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             ctrl_en,
    input  logic             ctrl_pol,
    input  logic [SEL_W-1:0] ctrl_cks,
    input  logic             tick,
    output logic             run_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pol_o,
    output logic [SEL_W-1:0] cks_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] TOP_V = CNT_W'(PERIOD_LEN - 1);

    chan_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             pol_q;
    logic [SEL_W-1:0] cks_q;
    logic             stop_req;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ctrl_we && ctrl_en)  state_d = ST_RUN;   // START
            ST_RUN:  if (ctrl_we && !ctrl_en) state_d = ST_IDLE;  // STOP
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign stop_req = (state_q == ST_RUN) && (state_d == ST_IDLE);
    assign wrap_o   = (state_q == ST_RUN) && !stop_req && tick && (cnt_q == TOP_V);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == ST_IDLE || stop_req) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= 1'b0;
            cks_q <= '0;
        end else if (ctrl_we) begin
            pol_q <= ctrl_pol;
            cks_q <= ctrl_cks;
        end
    end

    // outputs
    always_comb begin
        run_o = (state_q == ST_RUN);
        cnt_o = cnt_q;
        pol_o = pol_q;
        cks_o = cks_q;
    end
endmodule

// File: rtl/pwm_duty_buf.sv
module pwm_duty_buf #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wrap,
    input  logic             duty_we,
    input  logic [CNT_W-1:0] duty_wdata,
    output logic [CNT_W-1:0] act_o
);
    logic [CNT_W-1:0] buf_q, act_q, buf_next;

    assign buf_next = duty_we ? duty_wdata : buf_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            act_q <= '0;
        end else begin
            buf_q <= buf_next;
            if (!run || wrap) act_q <= buf_next;
        end
    end

    assign act_o = act_q;
endmodule

// File: rtl/pwm_shaper.sv
module pwm_shaper #(
    parameter int CNT_W      = 8,
    parameter int PERIOD_LEN = 250
) (
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] act,
    input  logic             pol,
    output logic             pwm_o,
    output logic             pwm_oe
);
    localparam logic [CNT_W-1:0] PER_V = CNT_W'(PERIOD_LEN);

    logic sat, level;

    always_comb begin
        sat    = (act >= PER_V);
        level  = sat || ((cnt != '0) && (cnt <= act));
        pwm_oe = run;
        pwm_o  = run && (level ^ pol);
    end
endmodule

// File: rtl/pwm_chan_top.sv
module pwm_chan_top #(
    parameter int CNT_W      = 8,
    parameter int PERIOD_LEN = 250,
    parameter int N_TICK     = 8,
    localparam int SEL_W     = $clog2(N_TICK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              duty_we,
    input  logic [CNT_W-1:0]  duty_wdata,
    input  logic              ctrl_we,
    input  logic              ctrl_en,
    input  logic              ctrl_pol,
    input  logic [SEL_W-1:0]  ctrl_cks,
    input  logic [N_TICK-1:0] tick_in,
    output logic              pwm_o,
    output logic              pwm_oe
);
    logic             run, wrap, pol_q, sel_tick;
    logic [CNT_W-1:0] cnt, act_duty;
    logic [SEL_W-1:0] cks_q;

    pwm_tick_sel #(.N_TICK(N_TICK)) u_sel (
        .tick_in (tick_in),
        .sel     (cks_q),
        .tick_o  (sel_tick)
    );

    pwm_ctrl_fsm #(.CNT_W(CNT_W), .PERIOD_LEN(PERIOD_LEN), .SEL_W(SEL_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (ctrl_we),
        .ctrl_en  (ctrl_en),
        .ctrl_pol (ctrl_pol),
        .ctrl_cks (ctrl_cks),
        .tick     (sel_tick),
        .run_o    (run),
        .cnt_o    (cnt),
        .pol_o    (pol_q),
        .cks_o    (cks_q),
        .wrap_o   (wrap)
    );

    pwm_duty_buf #(.CNT_W(CNT_W)) u_duty (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .wrap       (wrap),
        .duty_we    (duty_we),
        .duty_wdata (duty_wdata),
        .act_o      (act_duty)
    );

    pwm_shaper #(.CNT_W(CNT_W), .PERIOD_LEN(PERIOD_LEN)) u_shape (
        .run    (run),
        .cnt    (cnt),
        .act    (act_duty),
        .pol    (pol_q),
        .pwm_o  (pwm_o),
        .pwm_oe (pwm_oe)
    );
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
    parameter int CNT_W      = 8,
    parameter int PERIOD_LEN = 250
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] act,
    input logic             wrap,
    input logic             sel_tick,
    input logic             ctrl_we,
    input logic             pol,
    input logic             pwm_o
);
    localparam logic [CNT_W-1:0] TOP_V = CNT_W'(PERIOD_LEN - 1);
    localparam logic [CNT_W-1:0] PER_V = CNT_W'(PERIOD_LEN);

    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP_V);

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> cnt == '0);

    p_duty_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> $stable(act));

    p_zero_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act == '0) |-> pwm_o == pol);

    p_full_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act >= PER_V) |-> pwm_o != pol);

    p_start_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> cnt == '0);

    p_tick_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sel_tick && !ctrl_we) |=> $stable(cnt));
endmodule

bind pwm_chan_top pwm_chan_chk #(.CNT_W(CNT_W), .PERIOD_LEN(PERIOD_LEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .cnt      (cnt),
    .act      (act_duty),
    .wrap     (wrap),
    .sel_tick (sel_tick),
    .ctrl_we  (ctrl_we),
    .pol      (pol_q),
    .pwm_o    (pwm_o)
);

// File: tb/pwm_chan_top_test.sv
module pwm_chan_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       duty_we = 1'b0;
    logic [7:0] duty_wdata = '0;
    logic       ctrl_we = 1'b0;
    logic       ctrl_en = 1'b0;
    logic       ctrl_pol = 1'b0;
    logic [2:0] ctrl_cks = '0;
    logic [7:0] tick_in = '0;
    logic       pwm_o, pwm_oe;

    typedef struct {
        logic  o;
        logic  oe;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   tcount = 0;
    bit   done = 0;

    // reference state
    bit       m_run = 0, m_pol = 0;
    int       m_cnt = 0, m_act = 0, m_buf = 0, m_cks = 0;

    always #5 clk = ~clk;

    pwm_chan_top uut (
        .clk(clk), .rst_n(rst_n), .duty_we(duty_we), .duty_wdata(duty_wdata),
        .ctrl_we(ctrl_we), .ctrl_en(ctrl_en), .ctrl_pol(ctrl_pol),
        .ctrl_cks(ctrl_cks), .tick_in(tick_in), .pwm_o(pwm_o), .pwm_oe(pwm_oe)
    );

    task automatic model_edge();
        bit sel, stop, start, wrap;
        int nbuf;
        sel   = tick_in[m_cks];
        stop  = m_run && ctrl_we && !ctrl_en;
        start = !m_run && ctrl_we && ctrl_en;
        wrap  = m_run && !stop && sel && (m_cnt == 249);
        if (!rst_n) begin
            m_run = 0; m_pol = 0; m_cnt = 0; m_act = 0; m_buf = 0; m_cks = 0;
        end else begin
            nbuf = duty_we ? int'(duty_wdata) : m_buf;
            if (!m_run || wrap) m_act = nbuf;
            if (!m_run || stop) m_cnt = 0;
            else if (sel)       m_cnt = wrap ? 0 : m_cnt + 1;
            m_buf = nbuf;
            if (ctrl_we) begin m_pol = ctrl_pol; m_cks = int'(ctrl_cks); end
            if (start) m_run = 1;
            else if (stop) m_run = 0;
        end
    endtask

    function automatic bit exp_level();
        if (m_act >= 250) return 1'b1;
        return (m_cnt >= 1) && (m_cnt <= m_act);
    endfunction

    // driver: one clock, expected result pushed to the scoreboard
    task automatic step(string tag);
        exp_t e;
        for (int k = 0; k < 8; k++) tick_in[k] = ((tcount % (k + 1)) == 0);
        @(posedge clk);
        model_edge();
        #1;
        e.oe  = m_run;
        e.o   = m_run && (exp_level() ^ m_pol);
        e.tag = tag;
        q.push_back(e);
        duty_we = 1'b0;
        ctrl_we = 1'b0;
        tcount++;
    endtask

    task automatic steps(string tag, int n);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic wr_duty(logic [7:0] v);
        duty_we = 1'b1; duty_wdata = v;
    endtask

    task automatic wr_ctrl(logic en, logic pol, logic [2:0] cks);
        ctrl_we = 1'b1; ctrl_en = en; ctrl_pol = pol; ctrl_cks = cks;
    endtask

    // monitor
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (pwm_o !== e.o || pwm_oe !== e.oe) begin
                errors++;
                $display("FAIL %s: pwm_o=%b pwm_oe=%b expected pwm_o=%b pwm_oe=%b at %0t",
                         e.tag, pwm_o, pwm_oe, e.o, e.oe, $time);
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        steps("R10", 3);                     // reset state
        rst_n = 1'b1;
        steps("R10", 2);
        wr_duty(8'd5); step("R6");           // idle write, no drive
        steps("R6", 5);
        wr_ctrl(1, 0, 3'd0); step("R9");     // START
        steps("R4", 260);
        wr_duty(8'd20); step("R5");          // mid-period write deferred
        steps("R5", 300);
        steps("R1", 250);
        wr_ctrl(1, 1, 3'd0); step("R11");    // re-enable while running
        steps("R7", 260);
        wr_ctrl(0, 0, 3'd0); wr_duty(8'd40); step("R6"); // STOP with pending write
        steps("R6", 10);
        wr_duty(8'd0); step("R6");
        wr_ctrl(1, 0, 3'd0); step("R9");
        steps("R2", 260);
        wr_ctrl(0, 0, 3'd0); step("R6");
        wr_duty(8'd252); step("R6");
        wr_ctrl(1, 0, 3'd0); step("R9");
        steps("R3", 260);
        wr_ctrl(0, 1, 3'd0); wr_duty(8'd250); step("R6");
        wr_ctrl(1, 1, 3'd0); step("R9");
        steps("R3", 260);
        wr_ctrl(0, 0, 3'd0); wr_duty(8'd249); step("R6");
        wr_ctrl(1, 0, 3'd0); step("R4");
        steps("R4", 260);
        wr_ctrl(0, 0, 3'd0); wr_duty(8'd3); step("R6");
        wr_ctrl(1, 0, 3'd3); step("R8");     // slow tick source
        steps("R8", 1100);
        wr_duty(8'd100); step("R5");
        steps("R5", 1000);
        @(negedge clk); @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule